// File: doc/BRIEF.md
# Dual-Port Serial Field Delay Memory

This block stores a stream of fixed-width words and plays them back in the same order. The write port and the read port each run on their own clock. The two clocks may differ in phase and in frequency. Each port steps a sequential address counter, and a port reset sends that counter back to location zero. The distance between the two streams, counted in words, is therefore set by the moment at which each side is reset. A typical use is a video line or field delay.

Each port has two kinds of control. The first kind stops the port's counter. The second kind only gates the data while the counter keeps stepping. On the write side, the gating control lets a pass overwrite only selected locations and leave the rest as they were, which suits picture-in-picture. On the read side, the gating control blanks selected words, which gives data skipping.

The lowest locations sit in a small separate buffer. The first word after a read reset therefore comes out with the same one-edge latency as every other word. Depth, buffer size and word width are parameters. The full-size instance holds 262,144 words of 12 bits, arranged as 512 by 512. The defaults are smaller so that the block can be simulated.

Top module: `sfd_field_delay`

## Requirements
- R1: The read stream started by a read reset returns, in order, the words written after the matching write reset. The delay in words equals the spacing between the two resets.
- R2: Each port reset is sampled on that port's own clock. On the reset edge the port accesses location 0, provided its step enable is high, and the following access is at location 1. With the step enable low, the port's next access is still at location 0.
- R3: While `wr_en` is low, write clock edges neither store data nor move the write address.
- R4: While `rd_en` is low, read clock edges do not move the read address. After such an edge, `rd_valid` is 0 and `rd_q` is 0.
- R5: With `wr_en` high and `wr_keep` low, the addressed location keeps its earlier contents, and the write address still advances by one.
- R6: With `rd_en` high and `rd_show` low, the edge leaves `rd_valid` at 0 and `rd_q` at 0, and the read address still advances by one.
- R7: Each address counter wraps from DEPTH-1 to 0 when it advances. A later write to location k replaces what an earlier pass left there.
- R8: A read is due exactly one `rd_clk` edge after the access. This holds for the first word after a read reset and for the step from the last fast-buffer location (FAST_DEPTH-1) to the first main-array location (FAST_DEPTH).
- R9: When one edge both writes and reads the same location, the read returns the word that was stored there before that edge.
- R10: The two ports work correctly when their clocks have different periods, and while both ports are running at the same time.
- R11: After an edge with `rd_en` and `rd_show` both high, `rd_valid` is 1 and `rd_q` holds the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_rst | input | 1 | Synchronous write address reset, active high |
| wr_en | input | 1 | Write step enable; low freezes the write address |
| wr_keep | input | 1 | Write data gate; low skips the store but the address still steps |
| wr_d | input | DATA_W | Write data word |
| rd_clk | input | 1 | Read port clock |
| rd_rst | input | 1 | Synchronous read address reset, active high |
| rd_en | input | 1 | Read step enable; low freezes the read address |
| rd_show | input | 1 | Read data gate; low blanks the output but the address still steps |
| rd_q | output | DATA_W | Registered read word, zero when not valid |
| rd_valid | output | 1 | High after an edge that delivered a word |

## Verification
A write becomes visible to any read edge that comes strictly later. A read edge's result appears on `rd_q` and `rd_valid` right after that same `rd_clk` edge, with no further register stage. The bench drives every input on a falling edge and compares the outputs one time unit after the next rising edge. It takes the expected word from its own model memory. That model is updated on write edges, and it is read when a read access is driven, before the edge. For the read-before-write case both clocks are edge-aligned. The expected word is then taken before the model records the write of the same edge.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int unsigned WORD_W      = 12;
    localparam int unsigned FULL_DEPTH  = 512 * 512;

    // What a port does with the location it points at on one edge.
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,   // step enable low: counter frozen, nothing touched
        ACC_HOLE = 2'd1,   // stepping, data gated off
        ACC_XFER = 2'd2    // stepping, data moved
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic step, input logic gate);
        if (!step)
            return ACC_IDLE;
        return gate ? ACC_XFER : ACC_HOLE;
    endfunction

    function automatic logic [31:0] wrap_inc(input logic [31:0] a, input int unsigned depth);
        return (a == 32'(depth - 1)) ? 32'd0 : a + 32'd1;
    endfunction

endpackage

// File: rtl/sfd_addr_ctr.sv
module sfd_addr_ctr #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] acc_addr
);
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_nxt;

    always_comb begin
        acc_addr = rst ? '0 : ptr_q;
        ptr_nxt  = step ? AW'(sfd_pkg::wrap_inc(32'(acc_addr), DEPTH)) : acc_addr;
    end

    always_ff @(posedge clk) begin
        ptr_q <= ptr_nxt;
    end

    // R2: reset edge lands the pointer on 1 when stepping, else on 0
    assert_reset_origin_R2: assert property (@(posedge clk)
        rst |=> ptr_q == ($past(step) ? AW'(1) : AW'(0)));

    // R3/R4: no step, no movement
    assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(ptr_q));

    // R7: stepping past the last location returns to zero
    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (step && ptr_q == AW'(DEPTH - 1)) |=> ptr_q == '0);

    assert_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        32'(ptr_q) < DEPTH);

endmodule

// File: rtl/sfd_store.sv
module sfd_store #(
    parameter int unsigned DEPTH      = 1024,
    parameter int unsigned FAST_DEPTH = 256,
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned AW         = $clog2(DEPTH)
) (
    input  logic                 wclk,
    input  sfd_pkg::acc_kind_e   w_kind,
    input  logic [AW-1:0]        w_addr,
    input  logic [DATA_W-1:0]    w_data,
    input  logic                 rclk,
    input  sfd_pkg::acc_kind_e   r_kind,
    input  logic [AW-1:0]        r_addr,
    output logic                 r_valid,
    output logic [DATA_W-1:0]    r_data
);
    import sfd_pkg::*;

    localparam int unsigned MAIN_DEPTH = DEPTH - FAST_DEPTH;
    localparam int unsigned MW = (MAIN_DEPTH > 1) ? $clog2(MAIN_DEPTH) : 1;
    localparam int unsigned FW = (FAST_DEPTH > 1) ? $clog2(FAST_DEPTH) : 1;

    logic [DATA_W-1:0] word;

    generate
        if (FAST_DEPTH > 0) begin : g_split
            // Low locations live in a small buffer, the rest in the main array.
            logic [DATA_W-1:0] fast_mem [FAST_DEPTH];
            logic [DATA_W-1:0] main_mem [MAIN_DEPTH];
            logic              w_low;
            logic              r_low;

            assign w_low = 32'(w_addr) < FAST_DEPTH;
            assign r_low = 32'(r_addr) < FAST_DEPTH;

            always_ff @(posedge wclk) begin
                if (w_kind == ACC_XFER) begin
                    if (w_low)
                        fast_mem[FW'(w_addr)] <= w_data;
                    else
                        main_mem[MW'(w_addr - AW'(FAST_DEPTH))] <= w_data;
                end
            end

            always_comb begin
                if (r_low)
                    word = fast_mem[FW'(r_addr)];
                else
                    word = main_mem[MW'(r_addr - AW'(FAST_DEPTH))];
            end
        end else begin : g_flat
            logic [DATA_W-1:0] main_mem [DEPTH];

            always_ff @(posedge wclk) begin
                if (w_kind == ACC_XFER)
                    main_mem[w_addr] <= w_data;
            end

            always_comb word = main_mem[r_addr];
        end
    endgenerate

    // Read register: the old word is sampled before a same-edge write lands.
    always_ff @(posedge rclk) begin
        r_valid <= (r_kind == ACC_XFER);
        r_data  <= (r_kind == ACC_XFER) ? word : '0;
    end

endmodule

// File: rtl/sfd_field_delay.sv
module sfd_field_delay #(
    parameter int unsigned DEPTH      = 1024,
    parameter int unsigned FAST_DEPTH = 256,
    parameter int unsigned DATA_W     = sfd_pkg::WORD_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic              wr_keep,
    input  logic [DATA_W-1:0] wr_d,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic              rd_show,
    output logic [DATA_W-1:0] rd_q,
    output logic              rd_valid
);
    import sfd_pkg::*;

    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        acc_kind_e     kind;
        logic [AW-1:0] addr;
    } port_acc_t;

    port_acc_t wr_acc;
    port_acc_t rd_acc;

    assign wr_acc.kind = classify(wr_en, wr_keep);
    assign rd_acc.kind = classify(rd_en, rd_show);

    sfd_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ctr (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .step     (wr_en),
        .acc_addr (wr_acc.addr)
    );

    sfd_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ctr (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .step     (rd_en),
        .acc_addr (rd_acc.addr)
    );

    sfd_store #(
        .DEPTH      (DEPTH),
        .FAST_DEPTH (FAST_DEPTH),
        .DATA_W     (DATA_W),
        .AW         (AW)
    ) u_store (
        .wclk    (wr_clk),
        .w_kind  (wr_acc.kind),
        .w_addr  (wr_acc.addr),
        .w_data  (wr_d),
        .rclk    (rd_clk),
        .r_kind  (rd_acc.kind),
        .r_addr  (rd_acc.addr),
        .r_valid (rd_valid),
        .r_data  (rd_q)
    );

    // R6: a gated read edge leaves a blank, invalid output
    assert_blank_output_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_show) |=> (!rd_valid && rd_q == '0));

    // R4: a frozen read edge delivers nothing
    assert_idle_output_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_en |=> (!rd_valid && rd_q == '0));

    // R11: an enabled, shown read is flagged valid on the next edge
    assert_valid_flag_R11: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_show) |=> rd_valid);

endmodule

// File: tb/sfd_field_delay_bench.sv
module sfd_field_delay_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int FAST       = 64;
    localparam int DW         = 12;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_keep = 1'b0;
    logic [DW-1:0] wr_d = '0;
    logic          rd_rst = 1'b1;
    logic          rd_en = 1'b0;
    logic          rd_show = 1'b0;
    logic [DW-1:0] rd_q;
    logic          rd_valid;

    int rhalf = CLK_PERIOD / 2;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DW-1:0] model [DEPTH];
    int mw = 0;
    int mr = 0;

    sfd_field_delay #(.DEPTH(DEPTH), .FAST_DEPTH(FAST), .DATA_W(DW)) u_sfd_field_delay (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_keep(wr_keep), .wr_d(wr_d),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_show(rd_show),
        .rd_q(rd_q), .rd_valid(rd_valid)
    );

    initial forever #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    initial forever #(rhalf) rd_clk = ~rd_clk;

    function automatic logic [DW-1:0] pat(input int seed, input int i);
        return DW'(seed * 293 + i * 37 + 5);
    endfunction

    task automatic check(input string req, input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (rd_valid !== ev || rd_q !== ed) begin
            failures++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     req, rd_valid, rd_q, ev, ed);
        end
    endtask

    task automatic wr_cycle(input logic rst, input logic we, input logic keep, input logic [DW-1:0] d);
        int e;
        @(negedge wr_clk);
        wr_rst = rst; wr_en = we; wr_keep = keep; wr_d = d;
        @(posedge wr_clk);
        e = rst ? 0 : mw;
        if (we) begin
            if (keep) model[e] = d;
            mw = (e + 1) % DEPTH;
        end else begin
            mw = e;
        end
        #1;
        wr_rst = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd_cycle(input logic rst, input logic en, input logic show, input string req);
        int e;
        logic ev;
        logic [DW-1:0] ed;
        @(negedge rd_clk);
        rd_rst = rst; rd_en = en; rd_show = show;
        e  = rst ? 0 : mr;
        ev = en && show;
        ed = ev ? model[e] : '0;
        mr = en ? (e + 1) % DEPTH : e;
        @(posedge rd_clk);
        #1;
        check(req, ev, ed);
        rd_rst = 1'b0; rd_en = 1'b0;
    endtask

    task automatic write_run(input int seed, input int n);
        for (int i = 0; i < n; i++) wr_cycle(i == 0, 1'b1, 1'b1, pat(seed, i));
    endtask

    task automatic read_run(input int n, input string req);
        for (int i = 0; i < n; i++) rd_cycle(i == 0, 1'b1, 1'b1, req);
    endtask

    task automatic t_reset_state;
        rd_cycle(1'b1, 1'b0, 1'b0, "R2 reset state");
        wr_cycle(1'b1, 1'b0, 1'b1, 12'hABC);
        for (int i = 0; i < 4; i++) wr_cycle(1'b0, 1'b1, 1'b1, pat(9, i));
        for (int i = 0; i < 4; i++) rd_cycle(i == 0, 1'b1, 1'b1, "R2 first word at 0");
    endtask

    task automatic t_delay;
        write_run(1, 32);
        read_run(32, "R1 R11 ordered delay");
    endtask

    task automatic t_wr_freeze;
        wr_cycle(1'b1, 1'b1, 1'b1, pat(2, 0));
        for (int i = 1; i < 4; i++) wr_cycle(1'b0, 1'b1, 1'b1, pat(2, i));
        for (int i = 0; i < 3; i++) wr_cycle(1'b0, 1'b0, 1'b1, 12'hFFF);
        for (int i = 4; i < 8; i++) wr_cycle(1'b0, 1'b1, 1'b1, pat(2, i));
        read_run(8, "R3 write freeze");
    endtask

    task automatic t_rd_freeze;
        for (int i = 0; i < 3; i++) rd_cycle(i == 0, 1'b1, 1'b1, "R4 before freeze");
        for (int i = 0; i < 3; i++) rd_cycle(1'b0, 1'b0, 1'b1, "R4 frozen output");
        for (int i = 0; i < 3; i++) rd_cycle(1'b0, 1'b1, 1'b1, "R4 resume in order");
    endtask

    task automatic t_in_mask;
        write_run(3, 16);
        for (int i = 0; i < 16; i++) wr_cycle(i == 0, 1'b1, (i % 3) != 0, pat(4, i));
        read_run(16, "R5 masked write");
    endtask

    task automatic t_out_mask;
        for (int i = 0; i < 16; i++) rd_cycle(i == 0, 1'b1, (i % 4) != 1, "R6 skipped read");
    endtask

    task automatic t_wrap;
        write_run(5, DEPTH + 3);
        read_run(DEPTH + 2, "R7 wrap");
    endtask

    task automatic t_fast_edge;
        write_run(6, FAST + 4);
        read_run(FAST + 4, "R8 fast buffer edge");
    endtask

    task automatic t_rbw;
        int e;
        logic [DW-1:0] ed;
        write_run(7, 8);
        for (int i = 0; i < 8; i++) begin
            @(negedge wr_clk);
            wr_rst = (i == 0); wr_en = 1'b1; wr_keep = 1'b1; wr_d = pat(8, i);
            rd_rst = (i == 0); rd_en = 1'b1; rd_show = 1'b1;
            e  = (i == 0) ? 0 : mr;
            ed = model[e];
            mr = (e + 1) % DEPTH;
            @(posedge wr_clk);
            e = (i == 0) ? 0 : mw;
            model[e] = pat(8, i);
            mw = (e + 1) % DEPTH;
            #1;
            check("R9 read before write", 1'b1, ed);
            wr_rst = 1'b0; wr_en = 1'b0; rd_rst = 1'b0; rd_en = 1'b0;
        end
        read_run(8, "R9 new data after");
    endtask

    task automatic t_async;
        rhalf = 7;
        fork
            write_run(10, 64);
            begin
                repeat (20) @(posedge wr_clk);
                read_run(64, "R10 unrelated clocks");
            end
        join
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge wr_clk);
        t_reset_state();
        t_delay();
        t_wr_freeze();
        t_rd_freeze();
        t_in_mask();
        t_out_mask();
        t_wrap();
        t_fast_edge();
        t_rbw();
        t_async();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule